// File: doc/BRIEF.md
# Alarm Down-Counter with Interrupt Flag

This block is a periodic alarm. A counter steps down by one on every cycle where the `tick` input is high. When a tick arrives while the count is zero, the counter reloads from a preset register and a sticky status flag is raised. The interrupt request is the AND of that status flag and an interrupt-enable flag.

Software reaches the block through a small synchronous register port. It can read and write the counter and the preset. The enable flag and the status flag are never written directly. Each flag has a write-one-to-set location and a write-one-to-clear location, plus a read-only view. Writing the set-status location lets software raise an interrupt on purpose. A bus adapter or a clock-domain crossing, if needed, sits outside the block.

Top module: `alarm_timer`

## Requirements
- R1: After a synchronous active-low reset, the counter, preset, status flag and enable flag all read 0, and `irq` is 0.
- R2: Byte offset 0x00 holds the counter and offset 0x04 holds the preset. A write stores `wr_data[CNT_W-1:0]`, and a read returns the stored value zero-extended to DATA_W bits.
- R3: The counter decrements by exactly one on each tick while it is nonzero. Without a tick it holds its value.
- R4: A tick while the counter is 0 loads the preset into the counter and sets the status flag.
- R5: Writing a value with bit 0 = 1 to offset 0x0C sets the enable flag, and to offset 0x08 clears it. Writes with bit 0 = 0 to either offset change nothing. The enable flag reads at bit 0 of offset 0x14.
- R6: Writing a value with bit 0 = 1 to offset 0x1C sets the status flag, and to offset 0x18 clears it. The status flag reads at bit 0 of offset 0x10.
- R7: `irq` is 1 exactly when both the enable flag and the status flag are 1.
- R8: If a zero event and a clear-status write fall in the same cycle, the status flag ends up set.
- R9: A write to the counter in a cycle with a tick stores the written value rather than the decremented or reloaded one. If the old count was 0, the status flag is still set.
- R10: The write-only offsets 0x08, 0x0C, 0x18 and 0x1C read as 0. Any unmapped address also reads as 0, and writes to an unmapped address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count-enable pulse |
| addr | input | 5 | Byte address of the register access |
| wr_en | input | 1 | Write strobe for the current cycle |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Combinational read data for `addr` |
| irq | output | 1 | Interrupt request (status AND enable) |

## Verification
The bench builds the block with CNT_W = 16 and DATA_W = 32. The write data is therefore wider than the registers, so it can show that the upper bits of a write are dropped and that reads are zero-extended. The 16-bit width also allows preset values that make a missed decrement or a wrong reload easy to see. The bench aligns a tick with a clear-status write, and a tick with a counter write, so the same-cycle priorities are tested.

// File: rtl/alarm_pkg.sv
// Shared register offsets for the alarm timer.
// Assumes byte addressing with 32-bit aligned registers.
package alarm_pkg;
    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] OFS_COUNT   = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_PRESET  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR  = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_EN_SET  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT_RD = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_EN_RD   = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_ST_CLR  = 5'h18;
    localparam logic [ADDR_W-1:0] OFS_ST_SET  = 5'h1C;
    localparam int FLAG_EN   = 0;
    localparam int FLAG_STAT = 1;
    localparam int N_FLAGS   = 2;
endpackage

// File: rtl/alarm_counter.sv
// Down-counter with automatic reload and its preset register.
// On a tick the count steps down; at zero it reloads and pulses zero_evt.
// A software write to the counter takes priority over tick activity.
// Assumes tick is synchronous to clk.
module alarm_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_cnt,
    input  logic         wr_pre,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] cnt,
    output logic [W-1:0] preset,
    output logic         zero_evt
);
    logic at_zero;

    // Detect the reload condition: tick while the count is zero
    always_comb begin
        at_zero  = (cnt == '0);
        zero_evt = tick && at_zero;
    end

    // Preset register: written only by software
    always_ff @(posedge clk) begin
        if (!rst_n)      preset <= '0;
        else if (wr_pre) preset <= wr_val;
    end

    // Counter: software write, then reload, then decrement
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (wr_cnt)   cnt <= wr_val;
        else if (zero_evt) cnt <= preset;
        else if (tick)     cnt <= cnt - 1'b1;
    end

    // R3
    dec_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !at_zero && !wr_cnt) |=> (cnt == $past(cnt) - 1'b1));
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_cnt) |=> $stable(cnt));
    // R4
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && at_zero && !wr_cnt) |=> (cnt == $past(preset)));
    // R9
    sw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt == $past(wr_val)));
endmodule

// File: rtl/alarm_flag.sv
// One sticky flag that changes only through set and clear pulses.
// When set and clear arrive in the same cycle, set wins.
// Assumes set and clr are single-cycle pulses.
module alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Flag storage with set priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);
    // R5
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !q);
    // R5
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set && !clr) |=> $stable(q));
endmodule

// File: rtl/alarm_timer.sv
// Alarm timer top: register decode, counter, the two flags, read mux, irq.
// Reads are combinational. Writes take effect at the next clock edge.
// Assumes DATA_W >= CNT_W and a single access per cycle.
module alarm_timer #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic [alarm_pkg::ADDR_W-1:0] addr,
    input  logic                       wr_en,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       irq
);
    import alarm_pkg::*;

    localparam int PAD_W = DATA_W - CNT_W;

    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   preset;
    logic               zero_evt;
    logic               wr_cnt;
    logic               wr_pre;
    logic [N_FLAGS-1:0] f_set;
    logic [N_FLAGS-1:0] f_clr;
    logic [N_FLAGS-1:0] f_q;
    logic               one_bit;
    logic               unused_wdata_hi;

    assign unused_wdata_hi = ^wr_data[DATA_W-1:CNT_W];
    assign one_bit         = wr_en && wr_data[0];

    // Write decode for the counter, the preset and the flag strobes
    always_comb begin
        wr_cnt           = wr_en && (addr == OFS_COUNT);
        wr_pre           = wr_en && (addr == OFS_PRESET);
        f_set[FLAG_EN]   = one_bit && (addr == OFS_EN_SET);
        f_clr[FLAG_EN]   = one_bit && (addr == OFS_EN_CLR);
        f_set[FLAG_STAT] = (one_bit && (addr == OFS_ST_SET)) || zero_evt;
        f_clr[FLAG_STAT] = one_bit && (addr == OFS_ST_CLR);
    end

    alarm_counter #(.W(CNT_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_cnt  (wr_cnt),
        .wr_pre  (wr_pre),
        .wr_val  (wr_data[CNT_W-1:0]),
        .cnt     (cnt),
        .preset  (preset),
        .zero_evt(zero_evt)
    );

    for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
        alarm_flag u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (f_set[i]),
            .clr  (f_clr[i]),
            .q    (f_q[i])
        );
    end

    // Read mux: write-only and unmapped offsets return zero
    always_comb begin
        rd_data = '0;
        unique case (addr)
            OFS_COUNT:   rd_data = {{PAD_W{1'b0}}, cnt};
            OFS_PRESET:  rd_data = {{PAD_W{1'b0}}, preset};
            OFS_STAT_RD: rd_data[0] = f_q[FLAG_STAT];
            OFS_EN_RD:   rd_data[0] = f_q[FLAG_EN];
            default:     rd_data = '0;
        endcase
    end

    // Interrupt request from the two flags
    assign irq = f_q[FLAG_STAT] && f_q[FLAG_EN];

    // R4
    zero_sets_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> (rd_data[0] || addr != OFS_STAT_RD) && irq == f_q[FLAG_EN]);
    // R2
    preset_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pre |=> (preset == $past(wr_data[CNT_W-1:0])));
endmodule

// File: tb/alarm_timer_bench.sv
// Scoreboard bench: driver tasks queue expected reads, a monitor compares them.
module alarm_timer_bench;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 32;

    typedef struct {
        logic [4:0]        a;
        logic [DATA_W-1:0] exp;
        logic              chk_irq;
        logic              exp_irq;
        string             tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic [4:0]        addr = '0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic              irq;

    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;
    item_t sb_q[$];
    event  smp_ev;

    always #2 clk = ~clk;

    alarm_timer #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_alarm_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    // Monitor: pop each expected item once the read has settled
    initial begin
        forever begin
            @(smp_ev);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                total++;
                if (rd_data !== it.exp) begin
                    bad++;
                    $display("FAIL %s: addr %h rd_data=%h expected %h", it.tag, it.a, rd_data, it.exp);
                end
                if (it.chk_irq) begin
                    total++;
                    if (irq !== it.exp_irq) begin
                        bad++;
                        $display("FAIL %s: irq=%b expected %b", it.tag, irq, it.exp_irq);
                    end
                end
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [DATA_W-1:0] d, input logic tk);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1; tick = tk;
        @(posedge clk);
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b0; tick = 1'b1;
            @(posedge clk);
        end
    endtask

    task automatic rd(input logic [4:0] a, input logic [DATA_W-1:0] e,
                      input logic ci, input logic ei, input string tag);
        item_t it;
        @(negedge clk);
        addr = a; wr_en = 1'b0; tick = 1'b0;
        it.a = a; it.exp = e; it.chk_irq = ci; it.exp_irq = ei; it.tag = tag;
        sb_q.push_back(it);
        -> smp_ev;
        @(posedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        rd(5'h00, 0, 1, 0, "R1");
        rd(5'h04, 0, 1, 0, "R1");
        rd(5'h10, 0, 1, 0, "R1");
        rd(5'h14, 0, 1, 0, "R1");
        // R2 truncation and zero extension
        wr(5'h04, 32'h0001_2345, 0);
        rd(5'h04, 32'h2345, 0, 0, "R2");
        wr(5'h00, 32'hFFFF_0005, 0);
        rd(5'h00, 32'h0005, 0, 0, "R2");
        // R3 hold without tick, then decrement
        rd(5'h00, 32'h0005, 0, 0, "R3");
        pulse(1);
        rd(5'h00, 32'h0004, 0, 0, "R3");
        pulse(3);
        rd(5'h00, 32'h0001, 0, 0, "R3");
        rd(5'h10, 0, 0, 0, "R4");
        pulse(1);
        rd(5'h00, 0, 0, 0, "R3");
        rd(5'h10, 0, 0, 0, "R4");
        // R4 reload and status set; R7 irq low with enable off
        pulse(1);
        rd(5'h00, 32'h2345, 0, 0, "R4");
        rd(5'h10, 1, 1, 0, "R4_R7");
        // R5 enable set/clear, bit 0 only
        wr(5'h0C, 32'h0000_0000, 0);
        rd(5'h14, 0, 1, 0, "R5");
        wr(5'h0C, 32'h0000_0001, 0);
        rd(5'h14, 1, 1, 1, "R5_R7");
        wr(5'h08, 32'hFFFF_FFFE, 0);
        rd(5'h14, 1, 1, 1, "R5");
        wr(5'h08, 32'h0000_0001, 0);
        rd(5'h14, 0, 1, 0, "R5_R7");
        wr(5'h0C, 32'h0000_0001, 0);
        // R6 status clear/set
        wr(5'h18, 32'h0000_0001, 0);
        rd(5'h10, 0, 1, 0, "R6");
        wr(5'h1C, 32'h0000_0001, 0);
        rd(5'h10, 1, 1, 1, "R6_R7");
        wr(5'h18, 32'h0000_0001, 0);
        rd(5'h10, 0, 1, 0, "R6");
        // R10 write-only and unmapped offsets read zero
        rd(5'h08, 0, 0, 0, "R10");
        rd(5'h0C, 0, 0, 0, "R10");
        rd(5'h18, 0, 0, 0, "R10");
        rd(5'h1C, 0, 0, 0, "R10");
        wr(5'h02, 32'h0000_00AA, 0);
        rd(5'h02, 0, 0, 0, "R10");
        rd(5'h00, 32'h2345, 0, 0, "R10");
        // R8 zero event beats a same-cycle clear-status
        wr(5'h00, 32'h0000_0001, 0);
        pulse(1);
        rd(5'h00, 0, 0, 0, "R8");
        wr(5'h18, 32'h0000_0001, 1);
        rd(5'h10, 1, 1, 1, "R8");
        rd(5'h00, 32'h2345, 0, 0, "R8");
        // R9 counter write beats decrement and reload
        wr(5'h18, 32'h0000_0001, 0);
        wr(5'h00, 32'h0000_0077, 1);
        rd(5'h00, 32'h0077, 0, 0, "R9");
        rd(5'h10, 0, 1, 0, "R9");
        wr(5'h00, 32'h0000_0000, 0);
        wr(5'h00, 32'h0000_0010, 1);
        rd(5'h00, 32'h0010, 0, 0, "R9");
        rd(5'h10, 1, 1, 1, "R9");
        @(negedge clk);
        finish_run();
    end
endmodule